// File: doc/BRIEF.md
# UART Channel Interrupt Mask and Event Latch

This block sits beside one UART channel and decides when the channel raises its interrupt line. The host writes an 8-bit mask register. Each of seven bits arms one interrupt source, and one further bit requests sleep. Four sources are levels that the datapath already holds: the receive error flags, the modem status change flags, the transmitter-empty flag and the receive-data-ready flag. The other three are events that the block captures itself. These are a one-cycle Xoff-received pulse, a rising edge on the CTS pin and a rising edge on the RTS pin.

Each pin passes through a synchroniser before a small edge state machine examines it. That machine has the states EDGE_INIT, EDGE_LOW and EDGE_HIGH. EDGE_INIT waits until the synchroniser has filled and then moves to EDGE_LOW or EDGE_HIGH, matching the settled pin level, without raising an event. The transition from EDGE_LOW to EDGE_HIGH is the only one that emits a rise pulse. The transition from EDGE_HIGH back to EDGE_LOW is silent.

Every captured event goes into a sticky flag, which is a two-state machine with the states FLAG_IDLE and FLAG_SET. A set moves the flag from FLAG_IDLE to FLAG_SET. A clear moves it from FLAG_SET back to FLAG_IDLE, but only when no set arrives in the same cycle. The host reads the flags on a status port and clears them all with a one-cycle read strobe. The registered interrupt output is the OR of every source ANDed with its mask bit. A sleep request follows the sleep bit while no interrupt is asserted.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0x00, all three event flags are 0, `irq` is 0 and `sleep_req` is 0.
- R2: When `mask_wr` is high at a clock edge, `mask_wdata` is loaded into the mask register at that edge, and `mask_rdata` shows it from then on.
- R3: With mask bit 2 set, `irq` is 1 whenever any bit of `line_err` is 1. `irq` changes at the first clock edge after the input change.
- R4: With mask bit 3 set, `irq` is 1 whenever any bit of `modem_delta` is 1.
- R5: A pulse on `xoff_rx` sets event flag `evt_status[0]` at the next edge. With mask bit 5 set, that flag drives `irq` one edge later.
- R6: A 0-to-1 change of `cts_pin` sets `evt_status[2]` at the third edge after the change, with SYNC_STAGES=2. With mask bit 7 set, `irq` follows one edge after that. A 1-to-0 change sets nothing, and a pin that is already high when reset is released sets nothing.
- R7: A 0-to-1 change of `rts_pin` sets `evt_status[1]` with the same timing as R6, and mask bit 6 arms it.
- R8: Event flags latch even while their mask bit is 0. Setting the mask bit later raises `irq` at the second edge after the write.
- R9: A high `evt_rd` clears all event flags at the next edge. A flag whose event arrives in the same cycle stays set.
- R10: Mask bit 1 arms the `thr_empty` level, and mask bit 0 arms the `rx_ready` level.
- R11: `sleep_req` is 1 exactly when mask bit 4 is 1 and `irq` is 0. Mask bit 4 never raises `irq`.
- R12: `irq` falls at the first edge after its last armed cause is removed or its mask bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask register write data |
| mask_rdata | output | 8 | Mask register contents |
| line_err | input | 4 | Receive error flags (level) |
| modem_delta | input | 4 | Modem status change flags (level) |
| thr_empty | input | 1 | Transmitter empty (level) |
| rx_ready | input | 1 | Receive data ready (level) |
| xoff_rx | input | 1 | One-cycle Xoff-received pulse |
| cts_pin | input | 1 | CTS pin, asynchronous |
| rts_pin | input | 1 | RTS pin, asynchronous |
| evt_rd | input | 1 | Read-and-clear strobe for event flags |
| evt_status | output | 3 | Event flags: [2] CTS rise, [1] RTS rise, [0] Xoff |
| irq | output | 1 | Active-high interrupt request |
| sleep_req | output | 1 | Sleep request |

## Verification
The bench builds the block with its defaults: SYNC_STAGES=2, and four bits each of receive error and modem change flags. Two synchroniser stages make the rise detection visible at an exact cycle, so the third-edge flag and fourth-edge interrupt timing of the pin events is checked cycle by cycle. The four-bit widths let the vector table cover single error bits, all error bits and mixed sources under many mask values. The directed part covers the reset-time pin level, falling pin edges, latching while masked and a read that collides with a new event.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int MASK_W   = 8;

    // mask register bit positions
    localparam int MB_RXRDY = 0;
    localparam int MB_THRE  = 1;
    localparam int MB_LERR  = 2;
    localparam int MB_MDLT  = 3;
    localparam int MB_SLEEP = 4;
    localparam int MB_XOFF  = 5;
    localparam int MB_RTS   = 6;
    localparam int MB_CTS   = 7;

    // event flag positions on the status port
    localparam int EV_XOFF  = 0;
    localparam int EV_RTS   = 1;
    localparam int EV_CTS   = 2;
    localparam int EV_NUM   = 3;

    // number of synchronised pins watched for rising edges
    localparam int PIN_NUM  = 2;

    typedef enum logic [1:0] {
        EDGE_INIT = 2'd0,
        EDGE_LOW  = 2'd1,
        EDGE_HIGH = 2'd2
    } edge_state_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_SET  = 1'b1
    } flag_state_e;

endpackage

// File: rtl/pin_rise_fsm.sv
module pin_rise_fsm
    import uart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    localparam int CNT_W = $clog2(SYNC_STAGES + 1);
    localparam logic [CNT_W-1:0] FILL_DONE = CNT_W'(SYNC_STAGES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic [CNT_W-1:0]       fill_q;
    edge_state_e            state_q, state_d;

    // synchroniser chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
        end
    end

    assign lvl = sync_q[SYNC_STAGES-1];

    // counts edges until the chain holds a sample taken after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (state_q == EDGE_INIT && fill_q != FILL_DONE) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EDGE_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_INIT: begin
                if (fill_q == FILL_DONE) begin
                    state_d = lvl ? EDGE_HIGH : EDGE_LOW;
                end
            end
            EDGE_LOW: begin
                if (lvl) begin
                    state_d = EDGE_HIGH;
                end
            end
            EDGE_HIGH: begin
                if (!lvl) begin
                    state_d = EDGE_LOW;
                end
            end
            default: state_d = EDGE_INIT;
        endcase
    end

    // outputs
    always_comb begin
        rise = 1'b0;
        unique case (state_q)
            EDGE_INIT: rise = 1'b0;
            EDGE_LOW:  rise = lvl;
            EDGE_HIGH: rise = 1'b0;
            default:   rise = 1'b0;
        endcase
    end

    // a rise is a single-cycle pulse
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // no rise is reported before the chain has filled
    p_no_rise_in_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EDGE_INIT) |-> !rise);

endmodule

// File: rtl/sticky_flag.sv
module sticky_flag
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set)         state_d = FLAG_SET;
            FLAG_SET:  if (clr && !set) state_d = FLAG_IDLE;
            default:                    state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_SET);
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/irq_mask_combine.sv
module irq_mask_combine
    import uart_irq_pkg::*;
#(
    parameter int ERR_W   = 4,
    parameter int DELTA_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MASK_W-1:0]   mask,
    input  logic [ERR_W-1:0]    line_err,
    input  logic [DELTA_W-1:0]  modem_delta,
    input  logic                thr_empty,
    input  logic                rx_ready,
    input  logic [EV_NUM-1:0]   evt_flags,
    output logic                irq
);

    logic [MASK_W-1:0] cause;
    logic              irq_d;
    logic              irq_q;

    always_comb begin
        cause            = '0;
        cause[MB_RXRDY]  = rx_ready;
        cause[MB_THRE]   = thr_empty;
        cause[MB_LERR]   = |line_err;
        cause[MB_MDLT]   = |modem_delta;
        cause[MB_SLEEP]  = 1'b0;
        cause[MB_XOFF]   = evt_flags[EV_XOFF];
        cause[MB_RTS]    = evt_flags[EV_RTS];
        cause[MB_CTS]    = evt_flags[EV_CTS];
        irq_d            = |(cause & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q;

    // an asserted interrupt always had some mask bit set a cycle before
    p_irq_needs_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mask != '0));

    // a line error with its mask bit armed raises the interrupt next cycle
    p_line_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[MB_LERR] && (line_err != '0)) |=> irq);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ERR_W       = 4,
    parameter int DELTA_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_wr,
    input  logic [7:0]         mask_wdata,
    output logic [7:0]         mask_rdata,
    input  logic [ERR_W-1:0]   line_err,
    input  logic [DELTA_W-1:0] modem_delta,
    input  logic               thr_empty,
    input  logic               rx_ready,
    input  logic               xoff_rx,
    input  logic               cts_pin,
    input  logic               rts_pin,
    input  logic               evt_rd,
    output logic [2:0]         evt_status,
    output logic               irq,
    output logic               sleep_req
);

    localparam logic [MASK_W-1:0] SLEEP_ONLY = MASK_W'(1) << MB_SLEEP;

    logic [MASK_W-1:0]  mask_q;
    logic [PIN_NUM-1:0] pins;
    logic [PIN_NUM-1:0] pin_rise;
    logic [EV_NUM-1:0]  evt_set;
    logic [EV_NUM-1:0]  evt_flags;

    // mask register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= mask_wdata;
        end
    end

    assign mask_rdata = mask_q;

    // pin edge detectors: index 0 watches RTS, index 1 watches CTS
    assign pins = {cts_pin, rts_pin};

    for (genvar gi = 0; gi < PIN_NUM; gi++) begin : g_pin
        pin_rise_fsm #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_rise (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[gi]),
            .rise (pin_rise[gi])
        );
    end

    always_comb begin
        evt_set          = '0;
        evt_set[EV_XOFF] = xoff_rx;
        evt_set[EV_RTS]  = pin_rise[0];
        evt_set[EV_CTS]  = pin_rise[1];
    end

    for (genvar gf = 0; gf < EV_NUM; gf++) begin : g_flag
        sticky_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (evt_set[gf]),
            .clr  (evt_rd),
            .flag (evt_flags[gf])
        );
    end

    assign evt_status = evt_flags;

    irq_mask_combine #(
        .ERR_W  (ERR_W),
        .DELTA_W(DELTA_W)
    ) u_comb (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask       (mask_q),
        .line_err   (line_err),
        .modem_delta(modem_delta),
        .thr_empty  (thr_empty),
        .rx_ready   (rx_ready),
        .evt_flags  (evt_flags),
        .irq        (irq)
    );

    assign sleep_req = mask_q[MB_SLEEP] & ~irq;

    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_rdata == $past(mask_wdata)));

    p_sleep_bit_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == SLEEP_ONLY) |=> !irq);

    p_xoff_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_rx |=> evt_status[EV_XOFF]);

endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic [7:0] mask_rdata;
    logic [3:0] line_err = '0;
    logic [3:0] modem_delta = '0;
    logic       thr_empty = 1'b0;
    logic       rx_ready = 1'b0;
    logic       xoff_rx = 1'b0;
    logic       cts_pin = 1'b1;
    logic       rts_pin = 1'b0;
    logic       evt_rd = 1'b0;
    logic [2:0] evt_status;
    logic       irq;
    logic       sleep_req;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    uart_irq_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .mask_rdata (mask_rdata),
        .line_err   (line_err),
        .modem_delta(modem_delta),
        .thr_empty  (thr_empty),
        .rx_ready   (rx_ready),
        .xoff_rx    (xoff_rx),
        .cts_pin    (cts_pin),
        .rts_pin    (rts_pin),
        .evt_rd     (evt_rd),
        .evt_status (evt_status),
        .irq        (irq),
        .sleep_req  (sleep_req)
    );

    // mask, line_err, modem_delta, thr_empty, rx_ready, expected irq, expected sleep_req
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {8'h00, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h04, 4'h2, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h04, 4'h0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h08, 4'h0, 4'h8, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h02, 4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h01, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'h01, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h10, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h14, 4'h1, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'hF0, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_mask(input logic [7:0] v);
        mask_wr    = 1'b1;
        mask_wdata = v;
        tick();
        mask_wr    = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // reset, with CTS held high across release
        repeat (3) @(negedge clk);
        chk("R1", "mask_rdata", mask_rdata, 8'h00);
        chk("R1", "evt_status", {5'd0, evt_status}, 8'h00);
        chk("R1", "irq", {7'd0, irq}, 8'h00);
        chk("R1", "sleep_req", {7'd0, sleep_req}, 8'h00);
        rst_n = 1'b1;
        repeat (8) tick();
        // R6: a pin already high at reset release gives no event
        chk("R6", "cts high at reset", {5'd0, evt_status}, 8'h00);

        // table walk over level sources
        for (int i = 0; i < NV; i++) begin
            line_err    = VEC[i][11:8];
            modem_delta = VEC[i][7:4];
            thr_empty   = VEC[i][3];
            rx_ready    = VEC[i][2];
            write_mask(VEC[i][19:12]);
            tick();
            chk("R2", "mask_rdata", mask_rdata, VEC[i][19:12]);
            chk("R3 R4 R10", "irq", {7'd0, irq}, {7'd0, VEC[i][1]});
            chk("R11", "sleep_req", {7'd0, sleep_req}, {7'd0, VEC[i][0]});
        end
        line_err = '0; modem_delta = '0; thr_empty = 1'b0; rx_ready = 1'b0;
        write_mask(8'h00);
        tick();

        // R3 / R12: one-edge response to level changes
        write_mask(8'h04);
        tick();
        line_err = 4'h8;
        chk("R3", "irq before edge", {7'd0, irq}, 8'h00);
        tick();
        chk("R3", "irq after one edge", {7'd0, irq}, 8'h01);
        line_err = 4'h0;
        tick();
        chk("R12", "irq after cause removed", {7'd0, irq}, 8'h00);
        line_err = 4'h4;
        tick();
        write_mask(8'h00);
        tick();
        chk("R12", "irq after mask cleared", {7'd0, irq}, 8'h00);
        line_err = 4'h0;

        // R6: CTS falling edge gives no event, rising edge exact timing
        cts_pin = 1'b0;
        repeat (6) tick();
        chk("R6", "cts fall", {5'd0, evt_status}, 8'h00);
        write_mask(8'h80);
        tick();
        cts_pin = 1'b1;
        tick();
        tick();
        chk("R6", "cts flag at edge 2", {5'd0, evt_status}, 8'h00);
        tick();
        chk("R6", "cts flag at edge 3", {5'd0, evt_status}, 8'h04);
        chk("R6", "irq at edge 3", {7'd0, irq}, 8'h00);
        tick();
        chk("R6", "irq at edge 4", {7'd0, irq}, 8'h01);

        // R9: read clears, irq falls one edge later
        evt_rd = 1'b1;
        tick();
        evt_rd = 1'b0;
        chk("R9", "status after read", {5'd0, evt_status}, 8'h00);
        tick();
        chk("R9", "irq after read", {7'd0, irq}, 8'h00);

        // R7: RTS rising edge, with its mask bit off first (R8)
        write_mask(8'h00);
        rts_pin = 1'b1;
        repeat (3) tick();
        chk("R7", "rts flag", {5'd0, evt_status}, 8'h02);
        chk("R8", "irq while masked", {7'd0, irq}, 8'h00);
        write_mask(8'h40);
        chk("R8", "irq one edge after write", {7'd0, irq}, 8'h00);
        tick();
        chk("R8", "irq two edges after write", {7'd0, irq}, 8'h01);
        rts_pin = 1'b0;
        evt_rd = 1'b1;
        tick();
        evt_rd = 1'b0;
        tick();
        chk("R7", "irq after clear", {7'd0, irq}, 8'h00);

        // R5: Xoff pulse latched
        write_mask(8'h20);
        xoff_rx = 1'b1;
        tick();
        xoff_rx = 1'b0;
        chk("R5", "xoff flag", {5'd0, evt_status}, 8'h01);
        tick();
        chk("R5", "xoff irq", {7'd0, irq}, 8'h01);

        // R9: collision of read and new Xoff keeps the flag; CTS flag clears
        cts_pin = 1'b0;
        repeat (4) tick();
        cts_pin = 1'b1;
        repeat (3) tick();
        chk("R6", "cts flag with xoff", {5'd0, evt_status}, 8'h05);
        evt_rd  = 1'b1;
        xoff_rx = 1'b1;
        tick();
        evt_rd  = 1'b0;
        xoff_rx = 1'b0;
        chk("R9", "collision keeps xoff", {5'd0, evt_status}, 8'h01);
        evt_rd = 1'b1;
        tick();
        evt_rd = 1'b0;
        chk("R9", "second read clears", {5'd0, evt_status}, 8'h00);

        // R11: sleep drops while an interrupt is asserted
        write_mask(8'h14);
        line_err = 4'h1;
        tick();
        chk("R11", "sleep with irq", {7'd0, sleep_req}, 8'h00);
        line_err = 4'h0;
        tick();
        chk("R11", "sleep without irq", {7'd0, sleep_req}, 8'h01);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule